// File: doc/BRIEF.md
# ALU Condition Flag Selector

This unit sits after a 32-bit adder/ALU. It takes the two operands, the result and the carry-out of the operation, and turns them into a single branch or trap condition bit. From these values it derives a zero test, a signed less-than test (taken from the carry and the operand sign bits), an overflow test and a type-tag test. A 4-bit select code then chooses one of thirteen conditions.

The chosen bit is captured in a register on the clock edge that ends a compute phase, which is marked by `phase_en`. The output always comes from that register. Select codes outside the defined set give a false condition and set a sticky error flag. Only reset clears that flag.

Top module: `cond_select_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `cond_q` and `invalid_sel` are 0 after that edge.
- R2: On an edge where `phase_en` is 0, `cond_q` and `invalid_sel` keep their values. On an edge where `phase_en` is 1, `cond_q` takes the condition selected by that cycle's inputs and shows it after that edge.
- R3: Code 1 gives 1 exactly when every bit of `alu_res` is 0. Code 4 gives the inverse.
- R4: Let the less-than term be `carry_out` XOR MSB(`lhs`) XOR MSB(`rhs`). Code 2 gives this term and code 5 gives its inverse.
- R5: Code 3 gives (zero OR less-than). Code 6 gives the inverse of that.
- R6: Code 7 gives overflow, which is (`carry_out` XOR MSB(`alu_res`)) XOR (MSB(`lhs`) XOR MSB(`rhs`)).
- R7: Code 8 gives 1 when `carry_out` is 0. Code 10 gives 1 when `carry_out` is 1.
- R8: A value fails the tag test when its three most significant bits are not all equal. Code 9 gives 1 when any of `lhs`, `rhs` or `alu_res` fails. Code 11 gives the inverse.
- R9: Code 0 always gives 0 and code 12 always gives 1.
- R10: Codes 13, 14 and 15 captured with `phase_en` give `cond_q` = 0 and set `invalid_sel`. The flag stays at 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| phase_en | input | 1 | End of compute phase: capture the condition on this edge |
| sel | input | 4 | Condition select code |
| lhs | input | WIDTH | Left ALU operand |
| rhs | input | WIDTH | Right ALU operand |
| alu_res | input | WIDTH | ALU result |
| carry_out | input | 1 | Carry-out of the ALU |
| cond_q | output | 1 | Registered condition bit |
| invalid_sel | output | 1 | Sticky flag for an undefined select code |

## Verification
The bench goes after the following corner cases:
- **Sign-bit corners.** It drives results such as all-zero and all-ones, and every combination of operand sign bit and carry. If a design took less-than from the result MSB instead of the carry, code 2 would be wrong. If it dropped one XOR term from overflow, code 7 would be wrong.
- **Tag test.** It drives values whose top three bits are uniform, either 000 or 111, and values where only the third bit from the top differs. A tag test that compared only two bits, or ignored the result, would report such values as legal.
- **Held cycles.** It interleaves cycles with `phase_en` low, which would expose an output that follows the inputs.
- **Sticky flag.** It sends undefined codes before and after a reset. This would catch a flag that clears itself or that a reset fails to clear.

// File: rtl/cond_sel_pkg.sv
package cond_sel_pkg;

    typedef enum logic [3:0] {
        SEL_NEVER    = 4'd0,
        SEL_ZERO     = 4'd1,
        SEL_LESS     = 4'd2,
        SEL_LEQ      = 4'd3,
        SEL_NONZERO  = 4'd4,
        SEL_GEQ      = 4'd5,
        SEL_GREATER  = 4'd6,
        SEL_OVF      = 4'd7,
        SEL_INBOUND  = 4'd8,
        SEL_TAGBAD   = 4'd9,
        SEL_OUTBOUND = 4'd10,
        SEL_TAGOK    = 4'd11,
        SEL_FAULT    = 4'd12
    } cond_code_e;

    localparam int unsigned SEL_BITS  = 4;
    localparam int unsigned NUM_CODES = 13;

    typedef struct packed {
        logic zero;
        logic less;
        logic ovf;
        logic carry;
        logic tag_bad;
    } flag_set_t;

    function automatic logic code_defined(input logic [SEL_BITS-1:0] code);
        return int'(code) < NUM_CODES;
    endfunction

endpackage

// File: rtl/cond_flags.sv
module cond_flags
    import cond_sel_pkg::*;
#(
    parameter int unsigned WIDTH    = 32,
    parameter int unsigned TAG_BITS = 3
) (
    input  logic [WIDTH-1:0] lhs,
    input  logic [WIDTH-1:0] rhs,
    input  logic [WIDTH-1:0] alu_res,
    input  logic             carry_out,
    output flag_set_t        flags
);
    localparam int unsigned NUM_VALS = 3;
    localparam int unsigned TOP      = WIDTH - 1;
    localparam int unsigned TAG_LO   = WIDTH - TAG_BITS;

    logic [WIDTH-1:0]    vals [NUM_VALS];
    logic [NUM_VALS-1:0] bad_tag;
    logic                sign_diff;

    assign vals[0] = lhs;
    assign vals[1] = rhs;
    assign vals[2] = alu_res;

    for (genvar i = 0; i < NUM_VALS; i++) begin : g_tag
        logic [TAG_BITS-1:0] tag;
        assign tag        = vals[i][TOP:TAG_LO];
        assign bad_tag[i] = !((&tag) || (~|tag));
    end

    assign sign_diff = lhs[TOP] ^ rhs[TOP];

    always_comb begin
        flags         = '0;
        flags.zero    = ~|alu_res;
        flags.less    = carry_out ^ sign_diff;
        flags.ovf     = (carry_out ^ alu_res[TOP]) ^ sign_diff;
        flags.carry   = carry_out;
        flags.tag_bad = |bad_tag;
    end

endmodule

// File: rtl/cond_pick.sv
module cond_pick
    import cond_sel_pkg::*;
(
    input  flag_set_t             flags,
    input  logic [SEL_BITS-1:0]   sel,
    output logic                  cond,
    output logic                  bad_code
);
    logic le_term;

    assign le_term  = flags.zero | flags.less;
    assign bad_code = !code_defined(sel);

    always_comb begin
        case (cond_code_e'(sel))
            SEL_NEVER:    cond = 1'b0;
            SEL_ZERO:     cond = flags.zero;
            SEL_LESS:     cond = flags.less;
            SEL_LEQ:      cond = le_term;
            SEL_NONZERO:  cond = !flags.zero;
            SEL_GEQ:      cond = !flags.less;
            SEL_GREATER:  cond = !le_term;
            SEL_OVF:      cond = flags.ovf;
            SEL_INBOUND:  cond = !flags.carry;
            SEL_TAGBAD:   cond = flags.tag_bad;
            SEL_OUTBOUND: cond = flags.carry;
            SEL_TAGOK:    cond = !flags.tag_bad;
            SEL_FAULT:    cond = 1'b1;
            default:      cond = 1'b0;
        endcase
    end

endmodule

// File: rtl/cond_select_unit.sv
module cond_select_unit
    import cond_sel_pkg::*;
#(
    parameter int unsigned WIDTH    = 32,
    parameter int unsigned TAG_BITS = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             phase_en,
    input  logic [3:0]       sel,
    input  logic [WIDTH-1:0] lhs,
    input  logic [WIDTH-1:0] rhs,
    input  logic [WIDTH-1:0] alu_res,
    input  logic             carry_out,
    output logic             cond_q,
    output logic             invalid_sel
);
    flag_set_t flags;
    logic      cond_d;
    logic      bad_code;

    cond_flags #(.WIDTH(WIDTH), .TAG_BITS(TAG_BITS)) u_flags (
        .lhs       (lhs),
        .rhs       (rhs),
        .alu_res   (alu_res),
        .carry_out (carry_out),
        .flags     (flags)
    );

    cond_pick u_pick (
        .flags    (flags),
        .sel      (sel),
        .cond     (cond_d),
        .bad_code (bad_code)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cond_q      <= 1'b0;
            invalid_sel <= 1'b0;
        end else if (phase_en) begin
            cond_q      <= cond_d;
            invalid_sel <= invalid_sel | bad_code;
        end
    end

endmodule

// File: rtl/cond_select_checker.sv
module cond_select_checker #(
    parameter int unsigned WIDTH = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             phase_en,
    input logic [3:0]       sel,
    input logic [WIDTH-1:0] lhs,
    input logic [WIDTH-1:0] rhs,
    input logic [WIDTH-1:0] alu_res,
    input logic             carry_out,
    input logic             cond_q,
    input logic             invalid_sel
);
    assert_hold_when_idle_R2: assert property (@(posedge clk) disable iff (rst)
        !phase_en |=> ($stable(cond_q) && $stable(invalid_sel)));

    assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        invalid_sel |=> invalid_sel);

    assert_bad_code_R10: assert property (@(posedge clk) disable iff (rst)
        (phase_en && sel >= 4'd13) |=> (!cond_q && invalid_sel));

    assert_fault_true_R9: assert property (@(posedge clk) disable iff (rst)
        (phase_en && sel == 4'd12) |=> cond_q);

    assert_never_false_R9: assert property (@(posedge clk) disable iff (rst)
        (phase_en && sel == 4'd0) |=> !cond_q);

    assert_bound_R7: assert property (@(posedge clk) disable iff (rst)
        (phase_en && sel == 4'd8) |=> (cond_q == !$past(carry_out)));

    assert_overflow_R6: assert property (@(posedge clk) disable iff (rst)
        (phase_en && sel == 4'd7) |=>
        (cond_q == $past(carry_out ^ alu_res[WIDTH-1] ^ lhs[WIDTH-1] ^ rhs[WIDTH-1])));

    assert_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (phase_en && sel == 4'd1) |=> (cond_q == $past(alu_res == '0)));
endmodule

bind cond_select_unit cond_select_checker #(.WIDTH(WIDTH)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .phase_en    (phase_en),
    .sel         (sel),
    .lhs         (lhs),
    .rhs         (rhs),
    .alu_res     (alu_res),
    .carry_out   (carry_out),
    .cond_q      (cond_q),
    .invalid_sel (invalid_sel)
);

// File: tb/sim_cond_select_unit.sv
`timescale 1ns/1ps
module sim_cond_select_unit;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         phase_en = 1'b0;
    logic [3:0]   sel = '0;
    logic [W-1:0] lhs = '0, rhs = '0, alu_res = '0;
    logic         carry_out = 1'b0;
    logic         cond_q, invalid_sel;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    bit    m_cond = 0;
    bit    m_inv  = 0;
    string m_req  = "R1";

    always #2 clk = ~clk;

    cond_select_unit #(.WIDTH(W)) u0 (
        .clk(clk), .rst(rst), .phase_en(phase_en), .sel(sel),
        .lhs(lhs), .rhs(rhs), .alu_res(alu_res), .carry_out(carry_out),
        .cond_q(cond_q), .invalid_sel(invalid_sel)
    );

    function automatic bit tag_fails(input logic [W-1:0] v);
        int ones = int'(v[W-1]) + int'(v[W-2]) + int'(v[W-3]);
        return (ones != 0) && (ones != 3);
    endfunction

    function automatic string req_of(input int code);
        case (code)
            1, 4:    return "R3";
            2, 5:    return "R4";
            3, 6:    return "R5";
            7:       return "R6";
            8, 10:   return "R7";
            9, 11:   return "R8";
            0, 12:   return "R9";
            default: return "R10";
        endcase
    endfunction

    // behavioural reference, evaluated at each rising edge
    always @(posedge clk) begin
        bit z, lt, ov, tb;
        int code;
        z    = (alu_res == 0);
        lt   = (carry_out != (lhs[W-1] != rhs[W-1]));
        ov   = ((carry_out != alu_res[W-1]) != (lhs[W-1] != rhs[W-1]));
        tb   = tag_fails(lhs) || tag_fails(rhs) || tag_fails(alu_res);
        code = int'(sel);
        if (rst) begin
            m_cond = 0; m_inv = 0; m_req = "R1";
        end else if (!phase_en) begin
            m_req = "R2";
        end else begin
            m_req = req_of(code);
            case (code)
                0: m_cond = 0;
                1: m_cond = z;
                2: m_cond = lt;
                3: m_cond = z || lt;
                4: m_cond = !z;
                5: m_cond = !lt;
                6: m_cond = !(z || lt);
                7: m_cond = ov;
                8: m_cond = !carry_out;
                9: m_cond = tb;
                10: m_cond = carry_out;
                11: m_cond = !tb;
                12: m_cond = 1;
                default: begin m_cond = 0; m_inv = 1; end
            endcase
        end
    end

    // compare on every falling edge
    always @(negedge clk) begin
        if (!done) begin
            checks += 2;
            if (cond_q !== m_cond) begin
                errors++;
                $display("FAIL %s cond_q actual %0b expected %0b sel %0d", m_req, cond_q, m_cond, sel);
            end
            if (invalid_sel !== m_inv) begin
                errors++;
                $display("FAIL %s invalid_sel actual %0b expected %0b", m_req, invalid_sel, m_inv);
            end
        end
    end

    task automatic drive(input logic [W-1:0] l, input logic [W-1:0] r,
                         input logic [W-1:0] s, input logic c,
                         input int code, input logic en);
        @(negedge clk);
        #0.5;
        lhs = l; rhs = r; alu_res = s; carry_out = c;
        sel = 4'(code); phase_en = en;
    endtask

    task automatic sweep(input logic [W-1:0] l, input logic [W-1:0] r,
                         input logic [W-1:0] s, input logic c, input int last);
        for (int k = 0; k <= last; k++) begin
            drive(l, r, s, c, k, 1'b1);
        end
        drive(~l, ~r, ~s, ~c, 12, 1'b0);   // R2: held cycle
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #0.5 rst = 1'b0;
        // R3..R9: defined codes over corner operand sets
        sweep(32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 1'b0, 12);
        sweep(32'h8000_0000, 32'h0000_0001, 32'hFFFF_FFFF, 1'b0, 12);
        sweep(32'h7FFF_FFFF, 32'h0000_0001, 32'h8000_0000, 1'b0, 12);
        sweep(32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0000, 1'b1, 12);
        sweep(32'hE000_0000, 32'h1FFF_FFFF, 32'h0000_0005, 1'b1, 12);
        sweep(32'hC000_0000, 32'h0000_0000, 32'h0000_0000, 1'b0, 12);  // R8 lhs tag bad
        sweep(32'h0000_0000, 32'h2000_0000, 32'h0000_0000, 1'b0, 12);  // R8 rhs tag bad
        sweep(32'h0000_0000, 32'h0000_0000, 32'hA000_0000, 1'b1, 12);  // R8 result tag bad
        for (int n = 0; n < 200; n++) begin
            drive($urandom, $urandom, $urandom, 1'($urandom), n % 13, 1'($urandom % 4 != 0));
        end
        // R10: undefined codes, sticky, then reset clears
        sweep(32'h1234_5678, 32'h0000_0000, 32'hFFFF_FFFF, 1'b1, 15);
        drive(32'h0, 32'h0, 32'h0, 1'b0, 12, 1'b1);
        drive(32'h0, 32'h0, 32'h0, 1'b0, 1, 1'b1);
        @(negedge clk); #0.5 rst = 1'b1;           // R1
        @(negedge clk); #0.5 rst = 1'b0;
        drive(32'h0, 32'h0, 32'h0, 1'b0, 14, 1'b0); // R2: undefined code ignored while idle
        drive(32'h0, 32'h0, 32'h0, 1'b0, 13, 1'b1); // R10
        drive(32'h0, 32'h0, 32'h0, 1'b0, 12, 1'b1);
        for (int n = 0; n < 100; n++) begin
            drive($urandom, $urandom, $urandom, 1'($urandom), int'($urandom % 16), 1'($urandom % 2));
        end
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog expired actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule